// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the bus-facing side of a 1024-byte serial memory. It listens on a four-wire serial bus (clock, select, data in, data out) and also has a pause input. It works in clock modes 0 and 3. All bus inputs are brought into the system clock domain through a synchroniser, and the serial clock edges are found by oversampling. Every byte on the bus moves most significant bit first. The first byte after select falls is an opcode. Depending on the opcode, a 16-bit address field and data bytes follow.

Reads are served from an internal synchronous byte array. The read pointer steps after each byte and wraps at the top of the array, so a host can keep clocking and keep reading. Writes are not done here. Write-enable, write-disable, each received write data byte and the final commit are passed as one-cycle request pulses to a separate write controller. That controller fills the array through a plain write port. While the controller reports a write cycle in progress, array reads are refused, but status reads still work. A low pause input freezes the transfer at the current bit and releases the data-out line. When the pause ends, the transfer resumes from that same bit.

Top module: `smem_spi_slave`

## Requirements
- R1: Data in is sampled on rising serial clock edges while select is low, most significant bit first. The first 8 bits after select falls form the opcode. Clock idle low (mode 0) and clock idle high (mode 3) both work.
- R2: Opcode 03h followed by a 16-bit address starts a read. Only the low 10 address bits are used. The data bits appear on data-out, MSB first. Each bit changes on a falling clock edge, and the first bit is presented on the first falling edge after the last address bit.
- R3: After each byte of a read, the pointer moves to the next address, and 3FFh is followed by 000h.
- R4: The data-out enable is low whenever select is high, and low outside the read-data and status-data phases.
- R5: While the pause input is low, the data-out enable is low and clock and data-in transitions have no effect. After release, the transfer continues at the same bit.
- R6: If busy is high when a read needs a byte from the array, the read is refused. The data-out enable then stays low until select rises.
- R7: Opcode 05h shifts out the status input MSB first, repeated for every further 8 clocks. The status input is sampled at the start of each status byte.
- R8: Opcode 06h emits request kind 0 and opcode 04h emits request kind 1. Each is emitted only when select rises with exactly 8 bits clocked.
- R9: Opcode 02h and a 16-bit address are followed by data bytes. Each complete data byte emits request kind 2, with address (start + n) mod 1024 and the byte as data.
- R10: Request kind 3 (commit) is emitted when select rises after a write, but only if at least one data byte was received and no partial byte follows it.
- R11: Any other opcode produces no request and no output until select rises.
- R12: Every request is a single-cycle pulse on the request-valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause, active low |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Data-out drive enable (low means high-impedance) |
| busy | input | 1 | Write cycle in progress |
| status_in | input | 8 | Status byte returned by opcode 05h |
| ctl_valid | output | 1 | Request pulse to write controller |
| ctl_kind | output | 2 | 0 enable, 1 disable, 2 data byte, 3 commit |
| ctl_addr | output | 10 | Address of a data-byte request |
| ctl_data | output | 8 | Data of a data-byte request |
| mem_we | input | 1 | Array write strobe from write controller |
| mem_waddr | input | 10 | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The hardest case to reach is a pause in the middle of a read byte while the host keeps toggling clock and data in. If the block acted on those toggles, the rest of the stream would be off by one or more bits. The bench pauses inside a data byte, pulses the clock twice with the data line inverted, puts the clock back to its earlier level and then releases the pause. It then requires the same bit to come back, followed by the rest of the byte. Pointer wrap uses an address field whose six top bits are set and whose low bits sit just below 3FFh, clocked in mode 3.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int BYTE_W = 8;
  localparam int AFIELD_W = 16;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RDAT, PH_WDAT, PH_STAT, PH_SKIP, PH_CMD
  } phase_t;

  typedef enum logic [1:0] {
    REQ_WREN = 2'd0, REQ_WRDI = 2'd1, REQ_WDATA = 2'd2, REQ_COMMIT = 2'd3
  } req_t;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) st <= RST_VAL;
        else     st <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) st <= {STAGES{RST_VAL}};
        else     st <= {st[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/smem_spi_slave.sv
module smem_spi_slave
  import smem_pkg::*;
#(
  parameter int AW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_si,
  input  logic          spi_hold_n,
  output logic          spi_so,
  output logic          spi_so_oe,
  input  logic          busy,
  input  logic [7:0]    status_in,
  output logic          ctl_valid,
  output logic [1:0]    ctl_kind,
  output logic [AW-1:0] ctl_addr,
  output logic [7:0]    ctl_data,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata
);
  localparam logic [3:0] IDLE_PINS = 4'b1010;

  logic [3:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_prev, cs_prev;
  logic sck_rise, sck_fall, cs_rise;

  smem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
    .q   (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign cs_s   = pins_s[1];
  assign si_s   = pins_s[2];
  assign hold_s = pins_s[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;
  assign cs_rise  = cs_s & ~cs_prev;

  phase_t          phase;
  logic [2:0]      bitcnt;
  logic [7:0]      shreg;
  logic [7:0]      byte_nx;
  logic [7:0]      cur;
  logic [AW-1:0]   addr_sh;
  logic [AW-1:0]   addr_nx;
  logic [AW-1:0]   rd_addr;
  logic [AW-1:0]   wptr;
  logic            abyte;
  logic            is_rd;
  logic            live;
  logic            got_data;
  req_t            pend;
  logic            mem_re;
  logic [7:0]      mem_rdata;

  assign byte_nx = {shreg[6:0], si_s};
  assign addr_nx = {addr_sh[AW-2:0], si_s};

  smem_array #(.AW(AW), .DW(BYTE_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (rd_addr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_OPC;
      bitcnt    <= '0;
      shreg     <= '0;
      cur       <= '0;
      addr_sh   <= '0;
      rd_addr   <= '0;
      wptr      <= '0;
      abyte     <= 1'b0;
      is_rd     <= 1'b0;
      live      <= 1'b0;
      got_data  <= 1'b0;
      pend      <= REQ_WREN;
      mem_re    <= 1'b0;
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
      ctl_valid <= 1'b0;
      ctl_kind  <= '0;
      ctl_addr  <= '0;
      ctl_data  <= '0;
    end else begin
      ctl_valid <= 1'b0;
      mem_re    <= 1'b0;
      if (cs_s) begin
        if (cs_rise && bitcnt == 3'd0) begin
          if (phase == PH_CMD) begin
            ctl_valid <= 1'b1;
            ctl_kind  <= pend;
            ctl_addr  <= '0;
            ctl_data  <= '0;
          end else if (phase == PH_WDAT && got_data) begin
            ctl_valid <= 1'b1;
            ctl_kind  <= REQ_COMMIT;
            ctl_addr  <= wptr;
            ctl_data  <= '0;
          end
        end
        phase    <= PH_OPC;
        bitcnt   <= '0;
        abyte    <= 1'b0;
        live     <= 1'b0;
        got_data <= 1'b0;
      end else if (hold_s) begin
        if (sck_rise) begin
          shreg   <= byte_nx;
          bitcnt  <= bitcnt + 3'd1;
          addr_sh <= addr_nx;
          unique case (phase)
            PH_OPC: if (bitcnt == 3'd7) begin
              unique case (byte_nx)
                OP_READ:  begin is_rd <= 1'b1; phase <= PH_ADDR; end
                OP_WRITE: begin is_rd <= 1'b0; phase <= PH_ADDR; end
                OP_WREN:  begin pend <= REQ_WREN; phase <= PH_CMD; end
                OP_WRDI:  begin pend <= REQ_WRDI; phase <= PH_CMD; end
                OP_RDSR:  phase <= PH_STAT;
                default:  phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: if (bitcnt == 3'd7) begin
              abyte <= ~abyte;
              if (abyte) begin
                if (!is_rd) begin
                  wptr  <= addr_nx;
                  phase <= PH_WDAT;
                end else if (busy) begin
                  phase <= PH_SKIP;
                end else begin
                  rd_addr <= addr_nx;
                  mem_re  <= 1'b1;
                  phase   <= PH_RDAT;
                end
              end
            end
            PH_RDAT: if (bitcnt == 3'd7) begin
              if (busy) begin
                phase <= PH_SKIP;
                live  <= 1'b0;
              end else begin
                rd_addr <= rd_addr + 1'b1;
                mem_re  <= 1'b1;
              end
            end
            PH_WDAT: if (bitcnt == 3'd7) begin
              ctl_valid <= 1'b1;
              ctl_kind  <= REQ_WDATA;
              ctl_addr  <= wptr;
              ctl_data  <= byte_nx;
              wptr      <= wptr + 1'b1;
              got_data  <= 1'b1;
            end
            PH_CMD:  phase <= PH_SKIP;
            default: ;
          endcase
        end
        if (sck_fall && (phase == PH_RDAT || phase == PH_STAT)) begin
          live <= 1'b1;
          if (bitcnt == 3'd0) begin
            cur    <= (phase == PH_RDAT) ? mem_rdata : status_in;
            spi_so <= (phase == PH_RDAT) ? mem_rdata[7] : status_in[7];
          end else begin
            spi_so <= cur[3'd7 - bitcnt];
          end
        end
      end
      spi_so_oe <= ~cs_s & hold_s & live & ~cs_rise &
                   (phase == PH_RDAT || phase == PH_STAT);
    end
  end
endmodule

// File: rtl/smem_spi_chk.sv
module smem_spi_chk
  import smem_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_s,
  input logic          hold_s,
  input logic          so_oe,
  input logic          ctl_valid,
  input logic          mem_re,
  input logic          busy,
  input phase_t        phase,
  input logic [AW-1:0] rd_addr
);
  // R4
  cs_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !so_oe);

  // R5
  hold_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !so_oe);

  // R6
  busy_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> !busy);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RDAT && $past(phase) == PH_RDAT && rd_addr != $past(rd_addr))
      |-> (rd_addr - $past(rd_addr)) == AW'(1));

  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |=> !ctl_valid);
endmodule

bind smem_spi_slave smem_spi_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_s      (cs_s),
  .hold_s    (hold_s),
  .so_oe     (spi_so_oe),
  .ctl_valid (ctl_valid),
  .mem_re    (mem_re),
  .busy      (busy),
  .phase     (phase),
  .rd_addr   (rd_addr)
);

// File: tb/smem_spi_slave_tb.sv
`timescale 1ns/1ps
module smem_spi_slave_tb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic ctl_valid;
  logic [1:0] ctl_kind;
  logic [AW-1:0] ctl_addr;
  logic [7:0] ctl_data;
  logic mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [7:0] mem_wdata = '0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int cs_hi_cnt = 0;
  logic [7:0] model [DEPTH];
  logic [19:0] got_q [$];

  always #2.5 clk = ~clk;

  smem_spi_slave #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .busy(busy),
    .status_in(status_in), .ctl_valid(ctl_valid), .ctl_kind(ctl_kind),
    .ctl_addr(ctl_addr), .ctl_data(ctl_data), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every-clock reference: select high for a while means no drive (R4)
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
      if (cs_hi_cnt > 5) chk("R4 idle drive", so_oe, 0);
      if (ctl_valid) got_q.push_back({ctl_kind, ctl_addr, ctl_data});
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_x(bit mode3);
    sck = mode3;
    waitc(H);
    cs_n = 1'b0;
    waitc(H);
  endtask

  task automatic end_x(bit mode3);
    if (!mode3) begin sck = 1'b0; waitc(H); end
    cs_n = 1'b1;
    waitc(2 * H);
  endtask

  task automatic one_bit(logic b, bit drv, logic eb, string req, bit do_hold);
    sck = 1'b0;
    si = b;
    if (do_hold) begin
      waitc(H / 2);
      hold_n = 1'b0;
      waitc(6);
      chk("R5 paused drive", so_oe, 0);
      sck = 1'b1; si = ~b; waitc(4);
      sck = 1'b0; waitc(4);
      sck = 1'b1; waitc(4);
      sck = 1'b0; si = b; waitc(6);
      hold_n = 1'b1;
    end
    waitc(H);
    if (drv) begin
      chk({req, " drive"}, so_oe, 1);
      chk({req, " bit"}, so, eb);
    end else begin
      chk({req, " no drive"}, so_oe, 0);
    end
    sck = 1'b1;
    waitc(H);
  endtask

  task automatic send_byte(logic [7:0] b, string req);
    for (int i = 7; i >= 0; i--) one_bit(b[i], 1'b0, 1'b0, req, 1'b0);
  endtask

  task automatic recv_byte(logic [7:0] e, bit drv, string req, int hold_bit);
    for (int i = 7; i >= 0; i--) one_bit(1'b0, drv, e[i], req, (i == hold_bit));
  endtask

  task automatic do_read(bit mode3, logic [15:0] af, int n, bit refused,
                         int hold_byte, int hold_bit, string req);
    int a = int'(af[AW-1:0]);
    begin_x(mode3);
    send_byte(8'h03, req);
    send_byte(af[15:8], req);
    send_byte(af[7:0], req);
    for (int k = 0; k < n; k++)
      recv_byte(model[(a + k) % DEPTH], !refused, req, (k == hold_byte) ? hold_bit : -1);
    end_x(mode3);
  endtask

  task automatic exp_req(logic [1:0] k, logic [AW-1:0] ad, logic [7:0] d, string req);
    logic [19:0] g;
    chk({req, " request present"}, got_q.size() > 0, 1);
    if (got_q.size() > 0) begin
      g = got_q.pop_front();
      chk({req, " kind"}, g[19:18], k);
      if (k == 2'd2) begin
        chk({req, " addr"}, g[17:8], ad);
        chk({req, " data"}, g[7:0], d);
      end
    end
  endtask

  task automatic exp_none(string req);
    chk({req, " no request"}, got_q.size(), 0);
    got_q.delete();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    waitc(4);
    rst = 1'b0;
    waitc(2);
    chk("reset so_oe", so_oe, 0);
    chk("R12 reset ctl_valid", ctl_valid, 0);
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'((i * 37 + 11) ^ (i >> 3));
      mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = model[i];
      waitc(1);
    end
    mem_we = 1'b0;
    waitc(4);

    // R1 R2 mode 0 read, three bytes
    do_read(1'b0, 16'h0010, 3, 1'b0, -1, -1, "R1 R2 mode0 read");
    // R3 mode 3, junk top address bits, crosses 3FFh
    do_read(1'b1, 16'hFFFE, 4, 1'b0, -1, -1, "R3 wrap mode3 read");
    // R5 pause in the middle of the second data byte
    do_read(1'b0, 16'h0123, 3, 1'b0, 1, 4, "R5 paused read");
    // R6 busy refuses array read
    busy = 1'b1;
    do_read(1'b0, 16'h0040, 2, 1'b1, -1, -1, "R6 busy read");
    // R7 status read while busy, two repeats
    status_in = 8'hA6;
    begin_x(1'b0);
    send_byte(8'h05, "R7");
    recv_byte(8'hA6, 1'b1, "R7 status 1", -1);
    status_in = 8'h3C;
    recv_byte(8'h3C, 1'b1, "R7 status 2", -1);
    end_x(1'b0);
    busy = 1'b0;
    exp_none("R6 R7");

    // R8 enable and disable requests
    begin_x(1'b0); send_byte(8'h06, "R8"); end_x(1'b0);
    exp_req(2'd0, '0, '0, "R8 enable");
    begin_x(1'b1); send_byte(8'h04, "R8"); end_x(1'b1);
    exp_req(2'd1, '0, '0, "R8 disable");
    begin_x(1'b0); send_byte(8'h06, "R8"); one_bit(1'b1, 1'b0, 1'b0, "R8", 1'b0); end_x(1'b0);
    exp_none("R8 nine bits");

    // R9 R10 write with commit
    begin_x(1'b0);
    send_byte(8'h02, "R9"); send_byte(8'hFD, "R9"); send_byte(8'h05, "R9");
    send_byte(8'hA5, "R9"); send_byte(8'h3C, "R9");
    end_x(1'b0);
    exp_req(2'd2, 10'h105, 8'hA5, "R9 byte0");
    exp_req(2'd2, 10'h106, 8'h3C, "R9 byte1");
    exp_req(2'd3, '0, '0, "R10 commit");
    exp_none("R10 after commit");

    // R10 partial byte: no commit
    begin_x(1'b1);
    send_byte(8'h02, "R10"); send_byte(8'h03, "R10"); send_byte(8'hFF, "R10");
    send_byte(8'h77, "R10");
    for (int i = 0; i < 3; i++) one_bit(1'b1, 1'b0, 1'b0, "R10", 1'b0);
    end_x(1'b1);
    exp_req(2'd2, 10'h3FF, 8'h77, "R10 data");
    exp_none("R10 partial");

    // R11 unknown opcode then read-like traffic
    begin_x(1'b0);
    send_byte(8'hAB, "R11");
    send_byte(8'h00, "R11"); send_byte(8'h10, "R11");
    recv_byte(8'h00, 1'b0, "R11 silent", -1);
    end_x(1'b0);
    exp_none("R11");

    // R12 abort mid-address, then a clean read
    begin_x(1'b0); send_byte(8'h03, "R12"); send_byte(8'h00, "R12"); end_x(1'b0);
    do_read(1'b0, 16'h02AA, 1, 1'b0, -1, -1, "R12 after abort");
    exp_none("R12");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule